// File: doc/BRIEF.md
# Latched Ramp-Compare PWM Generator

This block turns a digital control word into a gate-drive waveform for a power switch. A free-running up-counter acts as a linear ramp. It climbs from zero to PERIOD-1 and then wraps, so the counter period is the switching period. Each clock the ramp is compared with a threshold, which is the control word minus a ramp offset, limited to the range zero to PERIOD. The duty cycle is therefore the threshold divided by PERIOD.

The output stage is a set/clear latch. It is set when a period begins and cleared when the ramp reaches the threshold. Once the gate has gone low in a period, nothing can raise it again before the next period begins, so noise on the control path cannot cause extra switching. The control word and offset are captured once per period, at the clock edge that begins the period. Changes made in the middle of a period are therefore deferred to the next period. A one-cycle strobe marks the first cycle of each period.

Top module: `ramp_pwm`

## Requirements
- R1: The internal ramp steps by one each clock from 0 to PERIOD-1 and then returns to 0, so consecutive period strobes are exactly PERIOD cycles apart.
- R2: `period_start_o` is high for exactly one cycle per period: the cycle in which the ramp is 0, immediately after a wrap.
- R3: In each period the gate is high for the first T cycles and low for the rest, where T is the held threshold. This makes the duty cycle T/PERIOD.
- R4: A threshold of 0 keeps the gate low for the whole period.
- R5: A threshold of PERIOD or more keeps the gate high in every cycle of the period, and it stays high without a gap across consecutive such periods.
- R6: The threshold is `ctrl_i - offset_i`. A negative difference gives 0, and a difference above PERIOD gives PERIOD.
- R7: `ctrl_i` and `offset_i` are sampled only at the clock edge that begins a period. A change later in the period has no effect until the next period.
- R8: After the gate goes low within a period, it stays low until the next period begins, whatever the inputs do.
- R9: While `rst` is high, the gate and strobe outputs are low, the ramp is held at 0 and the held threshold is cleared. The partial period that follows the release of reset keeps the gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | CTRL_W | Control word, unsigned |
| offset_i | input | CTRL_W | Ramp offset, subtracted from the control word |
| gate_o | output | 1 | Gate drive output |
| period_start_o | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
On every cycle, the assertions check four things:
- the ramp steps by one between wraps;
- the strobe only appears when the ramp is zero;
- the held threshold changes only at a period start;
- a low gate cannot rise except at a period start, and the end-point thresholds pin the gate low or high.

The bench's scenarios are needed for everything else:
- that the number of high cycles equals the saturated difference;
- that changes made mid-period are deferred;
- that the spacing between strobes is PERIOD cycles;
- how the gate behaves around reset.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

   // Saturating difference: (a - b) clamped into [0, lim]
   function automatic int unsigned sat_diff(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned lim);
      int unsigned d;
      d = (a > b) ? (a - b) : 0;
      return (d > lim) ? lim : d;
   endfunction

   // Plain clamp for the variant without offset correction
   function automatic int unsigned clamp_top(input int unsigned a,
                                             input int unsigned lim);
      return (a > lim) ? lim : a;
   endfunction

endpackage

// File: rtl/pwm_ramp_counter.sv
module pwm_ramp_counter #(
   parameter int unsigned PERIOD = 16,
   parameter int unsigned CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             start_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             start_q;

   always_comb begin
      cnt_nxt_o = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         start_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt_o;
         start_q <= (cnt_nxt_o == '0);
      end
   end

   assign cnt_o   = cnt_q;
   assign start_o = start_q;

   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

   AST_RAMP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == LAST) |=> (cnt_q == '0)); // R1

   AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      start_q |-> (cnt_q == '0)); // R2

endmodule

// File: rtl/pwm_threshold.sv
module pwm_threshold
   import pwm_ramp_pkg::*;
#(
   parameter int unsigned CTRL_W    = 8,
   parameter int unsigned THR_W     = 5,
   parameter int unsigned PERIOD    = 16,
   parameter bit          OFFSET_EN = 1'b1
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [CTRL_W-1:0] offset_i,
   output logic [THR_W-1:0]  thr_o
);
   generate
      if (OFFSET_EN) begin : g_offset
         always_comb begin
            thr_o = THR_W'(sat_diff(int'(ctrl_i), int'(offset_i), PERIOD));
         end
      end else begin : g_plain
         logic unused_offset;
         assign unused_offset = ^offset_i;
         always_comb begin
            thr_o = THR_W'(clamp_top(int'(ctrl_i), PERIOD));
         end
      end
   endgenerate

endmodule

// File: rtl/pwm_sr_stage.sv
module pwm_sr_stage #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned THR_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic [THR_W-1:0] thr_next_i,
   output logic [THR_W-1:0] thr_o,
   output logic             gate_o
);
   localparam int unsigned PAD_W = THR_W - CNT_W;

   logic [THR_W-1:0] thr_q;
   logic             gate_q;
   logic             set_evt;
   logic             clr_evt;

   always_comb begin
      set_evt = (cnt_nxt_i == '0);
      clr_evt = ({{PAD_W{1'b0}}, cnt_nxt_i} == thr_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         thr_q  <= '0;
         gate_q <= 1'b0;
      end else if (set_evt) begin
         thr_q  <= thr_next_i;
         gate_q <= (thr_next_i != '0);
      end else if (clr_evt) begin
         gate_q <= 1'b0;
      end
   end

   assign thr_o  = thr_q;
   assign gate_o = gate_q;

endmodule

// File: rtl/ramp_pwm.sv
module ramp_pwm #(
   parameter int unsigned PERIOD    = 16,
   parameter int unsigned CTRL_W    = 8,
   parameter bit          OFFSET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [CTRL_W-1:0] offset_i,
   output logic              gate_o,
   output logic              period_start_o
);
   localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam int unsigned THR_W = $clog2(PERIOD + 1);
   localparam logic [THR_W-1:0] FULL = THR_W'(PERIOD);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("ramp_pwm: PERIOD must be at least 2");
      end
      if (CTRL_W < 1 || CTRL_W > 31) begin : g_bad_ctrl
         $error("ramp_pwm: CTRL_W must lie in 1..31");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic [THR_W-1:0] thr_new;
   logic [THR_W-1:0] thr;
   logic             start;
   logic             gate;
   logic             unused_cnt;

   pwm_ramp_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ramp (
      .clk       (clk),
      .rst       (rst),
      .cnt_o     (cnt),
      .cnt_nxt_o (cnt_nxt),
      .start_o   (start)
   );

   pwm_threshold #(
      .CTRL_W(CTRL_W), .THR_W(THR_W), .PERIOD(PERIOD), .OFFSET_EN(OFFSET_EN)
   ) u_thr (
      .ctrl_i   (ctrl_i),
      .offset_i (offset_i),
      .thr_o    (thr_new)
   );

   pwm_sr_stage #(.CNT_W(CNT_W), .THR_W(THR_W)) u_latch (
      .clk        (clk),
      .rst        (rst),
      .cnt_nxt_i  (cnt_nxt),
      .thr_next_i (thr_new),
      .thr_o      (thr),
      .gate_o     (gate)
   );

   assign unused_cnt     = ^cnt;
   assign gate_o         = gate;
   assign period_start_o = start;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !start |-> $stable(thr)); // R7

   AST_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
      (!start && !$past(gate)) |-> !gate); // R8

   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
      (thr == '0) |-> !gate); // R4

   AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
      (thr == FULL) |-> gate); // R5

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!gate && !start)); // R9

endmodule

// File: tb/ramp_pwm_test.sv
`timescale 1ns/1ps
module ramp_pwm_test;
   localparam int PERIOD = 16;
   localparam int NV     = 13;
   localparam int unsigned VC [NV] = '{0, 16, 8, 200, 5, 10, 3, 20, 1, 15, 4, 17, 255};
   localparam int unsigned VO [NV] = '{0,  0, 0,   0, 0,  4, 4,  4, 0,  0, 4,  1, 255};
   localparam int unsigned VE [NV] = '{0, 16, 8,  16, 5,  6, 0, 16, 1, 15, 0, 16,   0};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] ctrl = '0;
   logic [7:0] offs = '0;
   logic       gate;
   logic       pstart;
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 1'b0;

   always #2 clk = ~clk;

   ramp_pwm #(.PERIOD(PERIOD), .CTRL_W(8), .OFFSET_EN(1'b1)) uut (
      .clk            (clk),
      .rst            (rst),
      .ctrl_i         (ctrl),
      .offset_i       (offs),
      .gate_o         (gate),
      .period_start_o (pstart)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_start(output int cyc, output int highs);
      cyc = 0; highs = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (!pstart) highs += int'(gate);
      end while (!pstart && cyc < 4 * PERIOD);
   endtask

   task automatic measure(output int highs, output int strobes);
      highs = 0; strobes = 0;
      for (int i = 0; i < PERIOD; i++) begin
         highs   += int'(gate);
         strobes += int'(pstart);
         if (i < PERIOD - 1) @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int c, h, s, late;
      // R9: reset state
      ctrl = 8'd8;
      repeat (5) @(negedge clk);
      check(gate == 1'b0, "R9 gate in reset", int'(gate), 0);
      check(pstart == 1'b0, "R9 strobe in reset", int'(pstart), 0);
      rst = 1'b0;
      // R9/R1: partial period after reset is off, first strobe after PERIOD cycles
      wait_start(c, h);
      check(h == 0, "R9 partial period gate", h, 0);
      check(c == PERIOD, "R1 first strobe spacing", c, PERIOD);
      measure(h, s);
      check(h == 8, "R3 first period highs", h, 8);

      // Vector table: R3 R4 R5 R6 R2 R1
      for (int v = 0; v < NV; v++) begin
         ctrl = VC[v][7:0];
         offs = VO[v][7:0];
         wait_start(c, h);
         check(c == 1, "R1 strobe spacing", c, 1);
         measure(h, s);
         check(h == int'(VE[v]), "R3/R6 high cycles", h, int'(VE[v]));
         check(s == 1, "R2 one strobe per period", s, 1);
      end

      // R5: continuous high across two full periods
      ctrl = 8'd16; offs = 8'd0;
      wait_start(c, h);
      h = 0;
      for (int i = 0; i < 2 * PERIOD; i++) begin
         h += int'(gate);
         if (i < 2 * PERIOD - 1) @(negedge clk);
      end
      check(h == 2 * PERIOD, "R5 no gap across periods", h, 2 * PERIOD);

      // R7: mid-period change before crossing is deferred
      ctrl = 8'd10;
      wait_start(c, h);
      h = 0;
      for (int i = 0; i < PERIOD; i++) begin
         h += int'(gate);
         if (i == 2) ctrl = 8'd3;
         if (i < PERIOD - 1) @(negedge clk);
      end
      check(h == 10, "R7 held value used", h, 10);
      wait_start(c, h);
      measure(h, s);
      check(h == 3, "R7 new value next period", h, 3);

      // R8: raising control after turn-off cannot turn gate on
      ctrl = 8'd4;
      wait_start(c, h);
      h = 0; late = 0;
      for (int i = 0; i < PERIOD; i++) begin
         h += int'(gate);
         if (i >= 4) late += int'(gate);
         if (i == 6) ctrl = 8'd12;
         if (i < PERIOD - 1) @(negedge clk);
      end
      check(late == 0, "R8 gate stays off", late, 0);
      check(h == 4, "R8 highs this period", h, 4);
      wait_start(c, h);
      measure(h, s);
      check(h == 12, "R7 raised value next period", h, 12);

      // R9: reset while gate high
      ctrl = 8'd16;
      wait_start(c, h);
      @(negedge clk);
      check(gate == 1'b1, "R5 gate high before reset", int'(gate), 1);
      rst = 1'b1;
      @(negedge clk);
      check(gate == 1'b0, "R9 gate cleared by reset", int'(gate), 0);
      check(pstart == 1'b0, "R9 strobe cleared by reset", int'(pstart), 0);
      @(negedge clk);
      rst = 1'b0;
      wait_start(c, h);
      check(h == 0, "R9 partial period after reset", h, 0);
      measure(h, s);
      check(h == PERIOD, "R5 full duty after reset", h, PERIOD);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule